// File: doc/BRIEF.md
# Bus-Matching Dual-Clock FIFO

This block buffers data between two unrelated clock domains. The write port and the read port each run on their own free-running clock. Either port can be 18 bits or 9 bits wide, so the buffer also converts between the two widths. When the widths differ, an endian setting picks which half of an 18-bit word goes first. Writes are qualified by an active-low write enable. Reads are qualified by an active-low read enable.

Data is stored in 9-bit units. A wide write adds two units and a narrow write adds one. A wide read takes two units and a narrow read takes one. The full flag and the half-full flag are computed in the write domain. The empty flag is computed in the read domain. Two almost-flags compare the fill level, counted in output-width words, against offsets that can be loaded through the write port.

There are two read modes:
- **Standard mode:** data appears on the output only after a read.
- **Fall-through mode:** the oldest word is presented on the output without a read, and the empty flag means "no valid word on the output".

Master reset clears everything and takes a fresh configuration from static inputs. Partial reset clears only the stored data. Retransmit rewinds the read side to the first stored unit.

Top module: `bmfifo`

## Requirements
- R1: After master reset, empty_o=1, full_o=0, hf_o=0, pae_o=1 and paf_o=0, and both offsets hold OFF_DEF (7).
- R2: With a narrow input and a narrow output, words come out in write order, with the value in dout_o[8:0] and zeros in dout_o[17:9].
- R3: With a wide input and a narrow output, each written word produces two reads. When big_end_i=1, din_i[17:9] is read first. When big_end_i=0, din_i[8:0] is read first.
- R4: With a narrow input and a wide output, two writes form one output word. When big_end_i=1, the first unit is placed in dout_o[17:9]. When big_end_i=0, the first unit is placed in dout_o[8:0]. While only one unit is stored, empty_o stays 1.
- R5: full_o=1 when the free units are fewer than one input word. A write attempted while full_o=1 changes no stored data.
- R6: In standard mode, a read while empty_o=1 leaves dout_o unchanged and leaves the FIFO empty.
- R7: hf_o=1 when the stored units exceed half of the depth (32 units at the default size).
- R8: In fall-through mode, the oldest word appears on dout_o with empty_o=0 without any read. Each read presents the next word. empty_o returns to 1 once no word is left.
- R9: Cycles with ld_ni=0 and wen_ni=0 store nothing. They load din_i[6:0] into the almost-empty offset first and then into the almost-full offset, alternating. pae_o=1 when the stored output words are at most the almost-empty offset. paf_o=1 when the free output words are at most the almost-full offset.
- R10: Partial reset empties the FIFO but keeps the loaded offsets and the latched configuration.
- R11: A one-cycle pulse on rt_i makes the next reads restart from the first unit written after the last reset.
- R12: With a wide input and a wide output, all 18 bits pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Master reset, active low, asynchronous |
| prs_ni | input | 1 | Partial reset, active low, asynchronous |
| in_wide_i | input | 1 | Input width: 1 = 18 bits, 0 = 9 bits (latched after master reset) |
| out_wide_i | input | 1 | Output width: 1 = 18 bits, 0 = 9 bits (latched) |
| fwft_i | input | 1 | 1 = fall-through read mode (latched) |
| big_end_i | input | 1 | 1 = upper half first (latched) |
| wen_ni | input | 1 | Write enable, active low |
| ld_ni | input | 1 | Offset load select, active low, used together with wen_ni |
| din_i | input | 18 | Write data; a narrow input uses bits [8:0] |
| ren_ni | input | 1 | Read enable, active low |
| rt_i | input | 1 | Retransmit pulse, read domain |
| dout_o | output | 18 | Read data |
| empty_o | output | 1 | Empty flag; in fall-through mode, no valid output word |
| full_o | output | 1 | Full flag |
| hf_o | output | 1 | Half-full flag |
| pae_o | output | 1 | Almost-empty flag |
| paf_o | output | 1 | Almost-full flag |

## Verification
All four width pairings are driven with distinct 9-bit halves. This shows whether units are split, joined and ordered correctly. Each mixed-width case is run under both endian settings, so a swapped half cannot pass.

A fill with 64 distinct values, followed by one extra write, separates a dropped write from an overwritten location. Offsets of 2 and 3 differ from the default of 7. Because of that, the almost-flag thresholds after a partial reset show whether the loaded offsets survived the reset.

Retransmit and fall-through are each tried with several words, so a pointer that rewinds to the wrong unit produces a different value.

// File: rtl/bmfifo_pkg.sv
`timescale 1ns/1ps
package bmfifo_pkg;
  localparam int UNIT_W = 9;
  localparam int WORD_W = 2 * UNIT_W;

  typedef struct packed {
    logic in_wide;
    logic out_wide;
    logic fwft;
    logic big_end;
  } cfg_t;
endpackage

// File: rtl/bmfifo_sync.sv
`timescale 1ns/1ps
module bmfifo_sync #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/bmfifo_cfg.sv
`timescale 1ns/1ps
module bmfifo_cfg
  import bmfifo_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cfg_t cfg_i,
  output cfg_t cfg_o
);
  logic vld_q;
  cfg_t cfg_q;

  // capture static settings on the first edge after master reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      cfg_q <= '0;
    end else if (!vld_q) begin
      vld_q <= 1'b1;
      cfg_q <= cfg_i;
    end
  end

  assign cfg_o = vld_q ? cfg_q : cfg_i;
endmodule

// File: rtl/bmfifo_wr.sv
`timescale 1ns/1ps
module bmfifo_wr #(
  parameter int AW      = 6,
  parameter int OFF_DEF = 7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ptr_rst_ni,
  input  logic        in_wide_i,
  input  logic        out_wide_i,
  input  logic        wen_ni,
  input  logic        ld_ni,
  input  logic [AW:0] off_i,
  input  logic [AW:0] rgray_i,
  output logic [AW:0] wptr_o,
  output logic [AW:0] wgray_o,
  output logic        we_o,
  output logic        full_o,
  output logic        hf_o,
  output logic        paf_o,
  output logic [AW:0] pae_off_o
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH = PW'(1 << AW);
  localparam logic [PW-1:0] HALF  = PW'(1 << (AW - 1));

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] rptr_s, cnt, free, step, free_w, paf_off_q;
  logic          sel_q, ld;

  assign rptr_s = out_wide_i ? (g2b(rgray_i >> 1) << 1) : g2b(rgray_i);
  assign cnt    = wptr_o - rptr_s;
  assign free   = DEPTH - cnt;
  assign step   = in_wide_i ? PW'(2) : PW'(1);
  assign free_w = out_wide_i ? (free >> 1) : free;
  assign full_o = free < step;
  assign hf_o   = cnt > HALF;
  assign paf_o  = free_w <= paf_off_q;
  assign ld     = !wen_ni && !ld_ni;
  assign we_o   = !wen_ni && ld_ni && !full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pae_off_o <= PW'(OFF_DEF);
      paf_off_q <= PW'(OFF_DEF);
      sel_q     <= 1'b0;
    end else if (ld) begin
      if (!sel_q) pae_off_o <= off_i;
      else        paf_off_q <= off_i;
      sel_q <= ~sel_q;
    end
  end

  // wide mode moves the pointer in pairs: encode the pair index so one bit flips per step
  always_ff @(posedge clk_i or negedge ptr_rst_ni) begin
    if (!ptr_rst_ni) begin
      wptr_o  <= '0;
      wgray_o <= '0;
    end else begin
      if (we_o) wptr_o <= wptr_o + step;
      wgray_o <= in_wide_i ? (b2g(wptr_o >> 1) << 1) : b2g(wptr_o);
    end
  end
endmodule

// File: rtl/bmfifo_rd.sv
`timescale 1ns/1ps
module bmfifo_rd #(
  parameter int AW = 6
) (
  input  logic        clk_i,
  input  logic        ptr_rst_ni,
  input  logic        in_wide_i,
  input  logic        out_wide_i,
  input  logic        fwft_i,
  input  logic        ren_ni,
  input  logic        rt_i,
  input  logic [AW:0] wgray_i,
  input  logic [AW:0] pae_off_i,
  input  logic [17:0] rdata_i,
  output logic [AW:0] rptr_o,
  output logic [AW:0] rgray_o,
  output logic [17:0] dout_o,
  output logic        empty_o,
  output logic        pae_o
);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wptr_s, cnt, step, cnt_w;
  logic          empty_mem, valid_q, fire;

  assign wptr_s    = in_wide_i ? (g2b(wgray_i >> 1) << 1) : g2b(wgray_i);
  assign cnt       = wptr_s - rptr_o;
  assign step      = out_wide_i ? PW'(2) : PW'(1);
  assign cnt_w     = out_wide_i ? (cnt >> 1) : cnt;
  assign empty_mem = cnt < step;
  assign pae_o     = cnt_w <= pae_off_i;
  assign fire      = fwft_i ? (!empty_mem && (!valid_q || !ren_ni))
                            : (!ren_ni && !empty_mem);
  assign empty_o   = fwft_i ? !valid_q : empty_mem;

  always_ff @(posedge clk_i or negedge ptr_rst_ni) begin
    if (!ptr_rst_ni) begin
      rptr_o  <= '0;
      rgray_o <= '0;
      dout_o  <= '0;
      valid_q <= 1'b0;
    end else begin
      rgray_o <= out_wide_i ? (b2g(rptr_o >> 1) << 1) : b2g(rptr_o);
      if (rt_i) begin
        rptr_o  <= '0;
        valid_q <= 1'b0;
      end else begin
        if (fire) begin
          rptr_o <= rptr_o + step;
          dout_o <= rdata_i;
        end
        if (fwft_i) valid_q <= fire ? 1'b1 : (!ren_ni ? 1'b0 : valid_q);
      end
    end
  end
endmodule

// File: rtl/bmfifo.sv
`timescale 1ns/1ps
module bmfifo
  import bmfifo_pkg::*;
#(
  parameter int AW      = 6,
  parameter int OFF_DEF = 7
) (
  input  logic        wclk_i,
  input  logic        rclk_i,
  input  logic        rst_ni,
  input  logic        prs_ni,
  input  logic        in_wide_i,
  input  logic        out_wide_i,
  input  logic        fwft_i,
  input  logic        big_end_i,
  input  logic        wen_ni,
  input  logic        ld_ni,
  input  logic [17:0] din_i,
  input  logic        ren_ni,
  input  logic        rt_i,
  output logic [17:0] dout_o,
  output logic        empty_o,
  output logic        full_o,
  output logic        hf_o,
  output logic        pae_o,
  output logic        paf_o
);
  localparam int DEPTH = 1 << AW;

  cfg_t cfg_in, cfg_w, cfg_r;
  logic ptr_rst_n, we;
  logic [AW:0] wptr_bin, rptr_bin, wgray, rgray, wgray_s, rgray_s, pae_off;
  logic [AW-1:0] waddr, raddr;
  logic [UNIT_W-1:0] u0, u1, r0, r1;
  logic [WORD_W-1:0] rdata;
  logic [UNIT_W-1:0] mem [DEPTH];

  assign cfg_in    = '{in_wide: in_wide_i, out_wide: out_wide_i, fwft: fwft_i, big_end: big_end_i};
  assign ptr_rst_n = rst_ni & prs_ni;

  bmfifo_cfg u_cfg_w (.clk_i(wclk_i), .rst_ni(rst_ni), .cfg_i(cfg_in), .cfg_o(cfg_w));
  bmfifo_cfg u_cfg_r (.clk_i(rclk_i), .rst_ni(rst_ni), .cfg_i(cfg_in), .cfg_o(cfg_r));

  bmfifo_sync #(.W(AW + 1)) u_w2r (.clk_i(rclk_i), .rst_ni(ptr_rst_n), .d_i(wgray), .q_o(wgray_s));
  bmfifo_sync #(.W(AW + 1)) u_r2w (.clk_i(wclk_i), .rst_ni(ptr_rst_n), .d_i(rgray), .q_o(rgray_s));

  bmfifo_wr #(.AW(AW), .OFF_DEF(OFF_DEF)) u_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .ptr_rst_ni(ptr_rst_n),
    .in_wide_i(cfg_w.in_wide), .out_wide_i(cfg_w.out_wide),
    .wen_ni(wen_ni), .ld_ni(ld_ni), .off_i(din_i[AW:0]), .rgray_i(rgray_s),
    .wptr_o(wptr_bin), .wgray_o(wgray), .we_o(we),
    .full_o(full_o), .hf_o(hf_o), .paf_o(paf_o), .pae_off_o(pae_off)
  );

  bmfifo_rd #(.AW(AW)) u_rd (
    .clk_i(rclk_i), .ptr_rst_ni(ptr_rst_n),
    .in_wide_i(cfg_r.in_wide), .out_wide_i(cfg_r.out_wide), .fwft_i(cfg_r.fwft),
    .ren_ni(ren_ni), .rt_i(rt_i), .wgray_i(wgray_s), .pae_off_i(pae_off),
    .rdata_i(rdata), .rptr_o(rptr_bin), .rgray_o(rgray),
    .dout_o(dout_o), .empty_o(empty_o), .pae_o(pae_o)
  );

  // unit split for writes, unit join for reads
  assign waddr = wptr_bin[AW-1:0];
  assign u0 = (cfg_w.in_wide && cfg_w.big_end) ? din_i[17:9] : din_i[8:0];
  assign u1 = cfg_w.big_end ? din_i[8:0] : din_i[17:9];

  always_ff @(posedge wclk_i) begin
    if (we) begin
      mem[waddr] <= u0;
      if (cfg_w.in_wide) mem[waddr + 1'b1] <= u1;
    end
  end

  assign raddr = rptr_bin[AW-1:0];
  assign r0    = mem[raddr];
  assign r1    = mem[raddr + 1'b1];
  assign rdata = !cfg_r.out_wide ? {{UNIT_W{1'b0}}, r0}
               : (cfg_r.big_end ? {r0, r1} : {r1, r0});
endmodule

// File: rtl/bmfifo_chk.sv
`timescale 1ns/1ps
module bmfifo_chk
  import bmfifo_pkg::*;
#(
  parameter int AW = 6
) (
  input logic        wclk_i,
  input logic        rclk_i,
  input logic        rst_ni,
  input logic        prs_ni,
  input logic        wen_ni,
  input logic        ld_ni,
  input logic        ren_ni,
  input logic        rt_i,
  input logic        full_o,
  input logic        hf_o,
  input logic        empty_o,
  input logic        pae_o,
  input cfg_t        cfg_w,
  input cfg_t        cfg_r,
  input logic [AW:0] wptr_bin,
  input logic [AW:0] rptr_bin
);
  logic live;
  assign live = rst_ni & prs_ni;

  assert_no_overflow_R5: assert property (@(posedge wclk_i) disable iff (!live)
    full_o && !wen_ni && ld_ni |=> $stable(wptr_bin));

  assert_wr_step_R3: assert property (@(posedge wclk_i) disable iff (!live)
    !full_o && !wen_ni && ld_ni |=>
      wptr_bin == $past(wptr_bin) + (AW+1)'($past(cfg_w.in_wide) ? 2 : 1));

  assert_full_half_R7: assert property (@(posedge wclk_i) disable iff (!live)
    full_o |-> hf_o);

  assert_no_underflow_R6: assert property (@(posedge rclk_i) disable iff (!live)
    !cfg_r.fwft && empty_o && !ren_ni && !rt_i |=> $stable(rptr_bin));

  assert_empty_pae_R9: assert property (@(posedge rclk_i) disable iff (!live)
    !cfg_r.fwft && empty_o |-> pae_o);

  assert_retx_R11: assert property (@(posedge rclk_i) disable iff (!live)
    rt_i |=> rptr_bin == '0);
endmodule

bind bmfifo bmfifo_chk #(.AW(AW)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni), .prs_ni(prs_ni),
  .wen_ni(wen_ni), .ld_ni(ld_ni), .ren_ni(ren_ni), .rt_i(rt_i),
  .full_o(full_o), .hf_o(hf_o), .empty_o(empty_o), .pae_o(pae_o),
  .cfg_w(cfg_w), .cfg_r(cfg_r), .wptr_bin(wptr_bin), .rptr_bin(rptr_bin)
);

// File: tb/sim_bmfifo.sv
`timescale 1ns/1ps
module sim_bmfifo;
  localparam int AW = 6;
  localparam int D  = 1 << AW;

  logic wclk = 0, rclk = 0, rst_ni = 0, prs_ni = 1;
  logic in_wide = 0, out_wide = 0, fwft = 0, big_end = 0;
  logic wen_ni = 1, ld_ni = 1, ren_ni = 1, rt_i = 0;
  logic [17:0] din = '0, dout;
  logic empty, full, hf, pae, paf;
  int vectors = 0, miscompares = 0;

  bmfifo #(.AW(AW), .OFF_DEF(7)) u0 (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni), .prs_ni(prs_ni),
    .in_wide_i(in_wide), .out_wide_i(out_wide), .fwft_i(fwft), .big_end_i(big_end),
    .wen_ni(wen_ni), .ld_ni(ld_ni), .din_i(din), .ren_ni(ren_ni), .rt_i(rt_i),
    .dout_o(dout), .empty_o(empty), .full_o(full), .hf_o(hf), .pae_o(pae), .paf_o(paf)
  );

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic mreset(input logic iw, input logic ow, input logic ff, input logic be);
    in_wide = iw; out_wide = ow; fwft = ff; big_end = be;
    rst_ni = 0;
    #20;
    rst_ni = 1;
    repeat (3) @(negedge rclk);
  endtask

  task automatic wr(input logic [17:0] d);
    @(negedge wclk); wen_ni = 0; din = d;
    @(negedge wclk); wen_ni = 1;
  endtask

  task automatic rd(output logic [17:0] d);
    @(negedge rclk); ren_ni = 0;
    @(negedge rclk); ren_ni = 1; d = dout;
  endtask

  task automatic settle();
    repeat (10) @(negedge rclk);
    @(negedge wclk);
  endtask

  task automatic t_reset();
    mreset(0, 0, 0, 0);
    check("R1 empty", 18'(empty), 18'd1);
    check("R1 full", 18'(full), 18'd0);
    check("R1 hf", 18'(hf), 18'd0);
    check("R1 pae", 18'(pae), 18'd1);
    check("R1 paf", 18'(paf), 18'd0);
  endtask

  task automatic t_narrow();
    logic [17:0] d, held;
    mreset(0, 0, 0, 0);
    wr(18'h3_F0AB); wr(18'h0_0155); wr(18'h0_01C3);
    settle();
    rd(d); check("R2 w0", d, 18'h000AB);
    rd(d); check("R2 w1", d, 18'h00155);
    rd(d); check("R2 w2", d, 18'h001C3);
    held = d;
    settle();
    rd(d); check("R6 dout held", d, held);
    check("R6 still empty", 18'(empty), 18'd1);
  endtask

  task automatic t_split(input logic be);
    logic [17:0] d;
    mreset(1, 0, 0, be);
    wr({9'h1A3, 9'h05C});
    settle();
    rd(d); check("R3 first half", d, be ? 18'h001A3 : 18'h0005C);
    rd(d); check("R3 second half", d, be ? 18'h0005C : 18'h001A3);
  endtask

  task automatic t_join(input logic be);
    logic [17:0] d;
    mreset(0, 1, 0, be);
    wr(18'h00111);
    settle();
    check("R4 one unit empty", 18'(empty), 18'd1);
    wr(18'h000AB);
    settle();
    rd(d); check("R4 joined", d, be ? {9'h111, 9'h0AB} : {9'h0AB, 9'h111});
  endtask

  task automatic t_wide();
    logic [17:0] d;
    mreset(1, 1, 0, 0);
    wr(18'h3C5A5);
    settle();
    rd(d); check("R12 wide pass", d, 18'h3C5A5);
  endtask

  task automatic t_full();
    logic [17:0] d;
    mreset(0, 0, 0, 0);
    for (int i = 0; i < 32; i++) wr(18'(i + 9'h40));
    check("R7 hf at half", 18'(hf), 18'd0);
    wr(18'(32 + 9'h40));
    check("R7 hf above half", 18'(hf), 18'd1);
    for (int i = 33; i < D; i++) wr(18'(i + 9'h40));
    check("R5 full", 18'(full), 18'd1);
    wr(18'h001FF);
    settle();
    for (int i = 0; i < D; i++) begin
      rd(d);
      if (d !== 18'(i + 9'h40)) check("R5 data after overfill", d, 18'(i + 9'h40));
    end
    check("R5 all data read", d, 18'(D - 1 + 9'h40));
    check("R5 empty after drain", 18'(empty), 18'd1);
    settle();
    check("R5 full cleared", 18'(full), 18'd0);
  endtask

  task automatic t_offsets();
    mreset(0, 0, 0, 0);
    @(negedge wclk); wen_ni = 0; ld_ni = 0; din = 18'd2;
    @(negedge wclk); din = 18'd3;
    @(negedge wclk); wen_ni = 1; ld_ni = 1;
    settle();
    check("R9 load stores nothing", 18'(empty), 18'd1);
    wr(18'h1); wr(18'h2);
    settle();
    check("R9 pae at offset", 18'(pae), 18'd1);
    wr(18'h3);
    settle();
    check("R9 pae above offset", 18'(pae), 18'd0);
    for (int i = 3; i < 60; i++) wr(18'(i));
    check("R9 paf free 4", 18'(paf), 18'd0);
    wr(18'h3C);
    check("R9 paf free 3", 18'(paf), 18'd1);
    @(negedge wclk); prs_ni = 0;
    #20; prs_ni = 1;
    settle();
    check("R10 empty after partial", 18'(empty), 18'd1);
    check("R10 paf cleared", 18'(paf), 18'd0);
    wr(18'h7); wr(18'h8);
    settle();
    check("R10 pae offset kept", 18'(pae), 18'd1);
    wr(18'h9);
    settle();
    check("R10 pae offset kept above", 18'(pae), 18'd0);
  endtask

  task automatic t_fwft();
    logic [17:0] d;
    mreset(0, 0, 1, 0);
    check("R8 initially empty", 18'(empty), 18'd1);
    wr(18'h055); wr(18'h0AA);
    settle();
    check("R8 fall-through data", dout, 18'h00055);
    check("R8 output ready", 18'(empty), 18'd0);
    rd(d); check("R8 next word", d, 18'h000AA);
    check("R8 still ready", 18'(empty), 18'd0);
    rd(d);
    check("R8 empty after last", 18'(empty), 18'd1);
  endtask

  task automatic t_retx();
    logic [17:0] d;
    mreset(0, 0, 0, 0);
    wr(18'h010); wr(18'h020); wr(18'h030);
    settle();
    rd(d); rd(d); check("R11 before rewind", d, 18'h020);
    @(negedge rclk); rt_i = 1;
    @(negedge rclk); rt_i = 0;
    rd(d); check("R11 rewind w0", d, 18'h010);
    rd(d); check("R11 rewind w1", d, 18'h020);
    rd(d); check("R11 rewind w2", d, 18'h030);
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_reset();
    t_narrow();
    t_split(1);
    t_split(0);
    t_join(1);
    t_join(0);
    t_wide();
    t_full();
    t_offsets();
    t_fwft();
    t_retx();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule